// File: doc/BRIEF.md
# Daisy-Chain Device Enumerator

This block finds out, after power-up, how many monitoring devices sit on a serial daisy chain. On a start pulse it issues three broadcast write frames: a control-low-byte write with software reset, address lock and chained readback enabled, then the same write without the reset, then a write that selects the control low byte as the register to read back. It then clocks out read frames one at a time and inspects what the chain returns.

Every device answers in turn with a frame carrying its own address. The enumerator checks the CRC of each returned frame and compares its bit-reversed address field with the frame's position in the sequence. The first all-zero frame marks the end of the chain, and the number of good frames seen before it is the device count. A bad frame stops enumeration with an I/O error, and a ninth good frame stops it with an overflow error. Count and error code stay put until the next accepted start.

Frames move across a simple 32-bit full-duplex handshake. The block raises `xfer_req_o` with a frame on `tx_frame_o`, and the serial shifter outside answers with a one-cycle `xfer_ack_i` carrying the word received during that transfer on `rx_frame_i`.

Top module: `chain_enum_top`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `xfer_req_o` are 0, `dev_count_o` is 0 and `err_o` is 0.
- R2: Write frames are built with the device address in bits 31:27 (0 here), the register in bits 26:21, the data byte in bits 20:13, broadcast bit 12 set, bit 11 clear, CRC in bits 10:3 and bits 2:0 equal to 3'b010. The CRC uses polynomial 0x2F over bits 31:11: a serial MSB-first CRC-8 with zero start over bits 31:19 zero-padded to 16 bits, XORed with the frame's bits 18:11.
- R3: The first frame after start writes register 0x0E with data bits 7, 4, 2 and 0 set.
- R4: The second frame writes register 0x0E with the same data but bit 7 clear, and the third writes register 0x1C with data 0x38.
- R5: Every read transfer sends the constant word 0xF800030A. The first all-zero returned frame ends enumeration with `err_o` = 0 (none) and `dev_count_o` equal to the number of nonzero frames before it.
- R6: A nonzero returned frame whose bits 9:2 differ from the R2-style CRC computed over its bits 31:10 (serial over bits 31:18, XOR bits 17:10) ends enumeration with `err_o` = 1 (I/O). `dev_count_o` gives the number of frames accepted before it.
- R7: A nonzero returned frame whose bits 31:27, read in reverse order (bit 31 as the LSB), differ from its zero-based position ends enumeration with `err_o` = 1 and the count of frames accepted before it.
- R8: If nine consecutive good nonzero frames are returned, enumeration ends after the ninth with `err_o` = 2 (overflow) and `dev_count_o` = 8.
- R9: The acquisition-time code sampled at start lands in data bits 6:5, and the thermistor enable lands in data bit 3, of both control-low-byte writes.
- R10: A start while busy is ignored. After completion, `done_o`, `dev_count_o` and `err_o` hold until the next start.
- R11: A frame is exchanged only in a cycle with `xfer_req_o` and `xfer_ack_i` both high. While a request is waiting, `tx_frame_o` and `xfer_req_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin enumeration (single-cycle pulse) |
| acq_time_i | input | 2 | Acquisition-time code for the control write |
| therm_en_i | input | 1 | Thermistor enable for the control write |
| xfer_req_o | output | 1 | Frame transfer request |
| tx_frame_o | output | 32 | Frame to send |
| xfer_ack_i | input | 1 | Transfer done; rx_frame_i valid |
| rx_frame_i | input | 32 | Frame received in that transfer |
| busy_o | output | 1 | Enumeration in progress |
| done_o | output | 1 | Result valid |
| dev_count_o | output | 4 | Devices found |
| err_o | output | 2 | 0 none, 1 I/O, 2 overflow |

## Verification
The hardest condition to reach is the overflow exit: it needs nine returned frames that are all well-formed, each with a correct CRC and the correct bit-reversed position. The bench's chain model builds every returned frame from its position, so asking the model for nine devices produces that run. Position and CRC faults are injected at chosen positions, and some cases stall the acknowledge to exercise the wait state.

// File: rtl/chain_enum_pkg.sv
package chain_enum_pkg;
  localparam logic [5:0]  REG_CTRL_LO = 6'h0E;
  localparam logic [5:0]  REG_RB_SEL  = 6'h1C;
  localparam logic [31:0] READ_WORD   = 32'hF800030A;
  localparam logic [7:0]  CRC_POLY    = 8'h2F;

  localparam logic [7:0] CTL_SWRST  = 8'h80;
  localparam logic [7:0] CTL_BASE   = 8'h15;  // fixed-one, addr lock, chained readback

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_IO   = 2'd1,
    ERR_OVF  = 2'd2
  } enum_err_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_READ = 2'd2
  } enum_state_e;

  // One byte through eight shift-and-reduce steps
  function automatic logic [7:0] crc_byte(input logic [7:0] b);
    logic [7:0] c;
    c = b;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/chain_crc8.sv
module chain_crc8 #(
  parameter int IN_W = 21
) (
  input  logic [IN_W-1:0] data_i,
  output logic [7:0]      crc_o
);
  import chain_enum_pkg::*;
  localparam int PAD = 24 - IN_W;

  logic [23:0] v;
  logic [7:0]  c_hi;

  assign v     = {{PAD{1'b0}}, data_i};
  assign c_hi  = crc_byte(v[23:16]);
  assign crc_o = crc_byte(c_hi ^ v[15:8]) ^ v[7:0];
endmodule

// File: rtl/chain_frame_build.sv
module chain_frame_build (
  input  logic [5:0]  reg_i,
  input  logic [7:0]  data_i,
  output logic [31:0] frame_o
);
  logic [20:0] body;
  logic [7:0]  crc;

  assign body = {5'd0, reg_i, data_i, 1'b1, 1'b0};

  chain_crc8 #(.IN_W(21)) crc_i (.data_i(body), .crc_o(crc));

  assign frame_o = {body, crc, 3'b010};
endmodule

// File: rtl/chain_frame_check.sv
module chain_frame_check #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4
) (
  input  logic [31:0]      frame_i,
  input  logic [IDX_W-1:0] pos_i,
  output logic             zero_o,
  output logic             ok_o
);
  logic [7:0]        crc;
  logic [ADDR_W-1:0] rev;

  chain_crc8 #(.IN_W(22)) crc_i (.data_i(frame_i[31:10]), .crc_o(crc));

  for (genvar g = 0; g < ADDR_W; g++) begin : g_rev
    assign rev[g] = frame_i[31 - g];
  end

  assign zero_o = (frame_i == 32'd0);
  assign ok_o   = (crc == frame_i[9:2]) && (8'(rev) == 8'(pos_i));
endmodule

// File: rtl/chain_enum_top.sv
module chain_enum_top #(
  parameter int MAX_DEV = 8,
  localparam int CNT_W  = $clog2(MAX_DEV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       acq_time_i,
  input  logic             therm_en_i,
  output logic             xfer_req_o,
  output logic [31:0]      tx_frame_o,
  input  logic             xfer_ack_i,
  input  logic [31:0]      rx_frame_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] dev_count_o,
  output logic [1:0]       err_o
);
  import chain_enum_pkg::*;

  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(2);
  localparam logic [CNT_W-1:0] MAX_IDX  = CNT_W'(MAX_DEV);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  enum_state_e      state_q, state_d;
  logic [CNT_W-1:0] step_q, step_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  enum_err_e        err_q, err_d;
  logic             done_q, done_d;
  logic [2:0]       cfg_q, cfg_d;
  logic             xfer;
  logic             rx_zero, rx_ok;
  logic [5:0]       cmd_reg;
  logic [7:0]       cmd_data;
  logic [31:0]      cmd_frame;

  assign xfer = xfer_req_o && xfer_ack_i;

  // command selection
  always_comb begin
    cmd_reg  = REG_CTRL_LO;
    cmd_data = CTL_BASE | {1'b0, cfg_q[2:1], 1'b0, cfg_q[0], 3'b000};
    if (step_q == '0) begin
      cmd_data = cmd_data | CTL_SWRST;
    end else if (step_q == LAST_CMD) begin
      cmd_reg  = REG_RB_SEL;
      cmd_data = {REG_CTRL_LO, 2'b00};
    end
  end

  chain_frame_build build_i (
    .reg_i  (cmd_reg),
    .data_i (cmd_data),
    .frame_o(cmd_frame)
  );

  chain_frame_check #(.ADDR_W(5), .IDX_W(CNT_W)) check_i (
    .frame_i(rx_frame_i),
    .pos_i  (step_q),
    .zero_o (rx_zero),
    .ok_o   (rx_ok)
  );

  // next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    done_d  = done_q;
    cfg_d   = cfg_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CMD;
          step_d  = '0;
          cnt_d   = '0;
          err_d   = ERR_NONE;
          done_d  = 1'b0;
          cfg_d   = {acq_time_i, therm_en_i};
        end
      end
      ST_CMD: begin
        if (xfer) begin
          if (step_q == LAST_CMD) begin
            state_d = ST_READ;
            step_d  = '0;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      ST_READ: begin
        if (xfer) begin
          if (rx_zero) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            cnt_d   = step_q;
          end else if (!rx_ok) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            cnt_d   = step_q;
            err_d   = ERR_IO;
          end else if (step_q == MAX_IDX) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            cnt_d   = MAX_IDX;
            err_d   = ERR_OVF;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cnt_q   <= '0;
      err_q   <= ERR_NONE;
      done_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      done_q  <= done_d;
      cfg_q   <= cfg_d;
    end
  end

  assign xfer_req_o  = (state_q != ST_IDLE);
  assign busy_o      = xfer_req_o;
  assign tx_frame_o  = (state_q == ST_READ) ? READ_WORD : cmd_frame;
  assign done_o      = done_q;
  assign dev_count_o = cnt_q;
  assign err_o       = err_q;

  // assertions
  p_frame_hold_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(tx_frame_o)));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy_o && start_i && !xfer_ack_i) |=> (busy_o && $stable(step_q)));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done_o && !start_i) |=> (done_o && $stable(dev_count_o) && $stable(err_o)));

  p_zero_end_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_READ && xfer && rx_zero) |=>
      (done_o && err_o == 2'd0 && dev_count_o == $past(step_q)));

  p_bad_frame_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_READ && xfer && !rx_zero && !rx_ok) |=> (done_o && err_o == 2'd1));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (err_o == 2'd2) |-> (dev_count_o == MAX_IDX));

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_o |-> !busy_o);
endmodule

// File: tb/chain_enum_top_tb_top.sv
module chain_enum_top_tb_top;
  localparam int MAXD = 8;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  acq_time_i;
  logic        therm_en_i;
  logic        xfer_req_o;
  logic [31:0] tx_frame_o;
  logic        xfer_ack_i;
  logic [31:0] rx_frame_i;
  logic        busy_o;
  logic        done_o;
  logic [3:0]  dev_count_o;
  logic [1:0]  err_o;

  int checks;
  int errors;
  bit finished;

  chain_enum_top #(.MAX_DEV(MAXD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .acq_time_i(acq_time_i),
    .therm_en_i(therm_en_i), .xfer_req_o(xfer_req_o), .tx_frame_o(tx_frame_o),
    .xfer_ack_i(xfer_ack_i), .rx_frame_i(rx_frame_i), .busy_o(busy_o),
    .done_o(done_o), .dev_count_o(dev_count_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  typedef struct packed {
    logic [3:0] ndev;
    logic [1:0] acq;
    logic       th;
    logic [1:0] fault;   // 0 none, 1 crc, 2 address
    logic [3:0] fpos;
    logic [3:0] ecnt;
    logic [1:0] eerr;
    logic [4:0] ereads;
    logic [1:0] stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 2'd0, 1'b0, 2'd0, 4'd0, 4'd0, 2'd0, 5'd1, 2'd0},
    '{4'd1, 2'd1, 1'b0, 2'd0, 4'd0, 4'd1, 2'd0, 5'd2, 2'd1},
    '{4'd3, 2'd2, 1'b1, 2'd0, 4'd0, 4'd3, 2'd0, 5'd4, 2'd0},
    '{4'd8, 2'd3, 1'b0, 2'd0, 4'd0, 4'd8, 2'd0, 5'd9, 2'd2},
    '{4'd9, 2'd0, 1'b1, 2'd0, 4'd0, 4'd8, 2'd2, 5'd9, 2'd0},
    '{4'd5, 2'd1, 1'b1, 2'd1, 4'd2, 4'd2, 2'd1, 5'd3, 2'd1},
    '{4'd4, 2'd0, 1'b0, 2'd2, 4'd0, 4'd0, 2'd1, 5'd1, 2'd0},
    '{4'd6, 2'd2, 1'b0, 2'd2, 4'd5, 4'd5, 2'd1, 5'd6, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial MSB-first CRC over bits 23:8, then XOR the low byte
  function automatic logic [7:0] ref_crc(input logic [23:0] v);
    logic [7:0] c;
    logic fb;
    c = 8'd0;
    for (int i = 23; i >= 8; i--) begin
      fb = c[7] ^ v[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h2F : 8'h00);
    end
    return c ^ v[7:0];
  endfunction

  function automatic logic [4:0] rev5(input logic [4:0] a);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = a[4 - i];
    return r;
  endfunction

  function automatic logic [31:0] wr_frame(input logic [5:0] rg, input logic [7:0] d);
    logic [20:0] body;
    body = {5'd0, rg, d, 1'b1, 1'b0};
    return {body, ref_crc({3'b000, body}), 3'b010};
  endfunction

  function automatic logic [31:0] exp_cmd(input int idx, input logic [1:0] acq, input logic th);
    logic [7:0] d;
    d = 8'h15 | {1'b0, acq, 1'b0, th, 3'b000};
    if (idx == 0) return wr_frame(6'h0E, d | 8'h80);   // R3 with R9 fields
    if (idx == 1) return wr_frame(6'h0E, d);           // R4
    return wr_frame(6'h1C, 8'h38);                     // R4
  endfunction

  function automatic logic [31:0] dev_frame(input int k, input vec_t v);
    logic [31:0] f;
    logic [4:0] a;
    if (k >= int'(v.ndev)) return 32'd0;
    a = rev5(5'(k));
    if (v.fault == 2'd2 && k == int'(v.fpos)) a = rev5(5'(k + 1));
    f = {a, 6'h0E, 8'(k * 17 + 3), 13'd0};
    f[9:2] = ref_crc({2'b00, f[31:10]});
    if (v.fault == 2'd1 && k == int'(v.fpos)) f[2] = ~f[2];
    return f;
  endfunction

  task automatic run_case(input vec_t v, input int inj, input string tag);
    int fi, st, cyc;
    logic [31:0] hold;
    fi = 0; st = 0; cyc = 0; hold = '0;
    @(negedge clk);
    acq_time_i = v.acq; therm_en_i = v.th; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    acq_time_i = ~v.acq; therm_en_i = ~v.th;  // R9: sampled at start only
    while (cyc < 2000) begin
      cyc++;
      if (xfer_ack_i) begin
        xfer_ack_i = 1'b0; start_i = 1'b0;
        if (done_o) break;
      end else if (done_o) begin
        break;
      end else if (xfer_req_o) begin
        if (st == 0) hold = tx_frame_o;
        else chk(tx_frame_o == hold, "R11 frame stable while waiting", tx_frame_o, hold);
        if (st == int'(v.stall)) begin
          if (fi < 3) chk(tx_frame_o == exp_cmd(fi, v.acq, v.th),
                          fi == 0 ? "R3 R2 R9 first write" : "R4 R2 R9 later write",
                          tx_frame_o, exp_cmd(fi, v.acq, v.th));
          else chk(tx_frame_o == 32'hF800030A, "R5 read word", tx_frame_o, 32'hF800030A);
          rx_frame_i = (fi < 3) ? 32'd0 : dev_frame(fi - 3, v);
          xfer_ack_i = 1'b1;
          fi++;
          st = 0;
          if (fi == inj) start_i = 1'b1;  // R10 start while busy
        end else begin
          st++;
        end
      end
      @(negedge clk);
    end
    chk(cyc < 2000, {"watchdog ", tag}, cyc, 2000);
    chk(done_o == 1'b1 && busy_o == 1'b0, {"R5 done ", tag}, {done_o, busy_o}, 2'b10);
    chk(dev_count_o == v.ecnt, {"R5 R6 R7 R8 count ", tag}, dev_count_o, v.ecnt);
    chk(err_o == v.eerr, {"R5 R6 R7 R8 error ", tag}, err_o, v.eerr);
    chk(fi == 3 + int'(v.ereads), {"R10 R11 frame total ", tag}, fi, 3 + v.ereads);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t d2;
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; acq_time_i = '0; therm_en_i = 1'b0;
    xfer_ack_i = 1'b0; rx_frame_i = '0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, xfer_req_o, dev_count_o, err_o} == '0, "R1 in reset",
        {busy_o, done_o, xfer_req_o, dev_count_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, done_o, xfer_req_o, dev_count_o, err_o} == '0, "R1 after release",
        {busy_o, done_o, xfer_req_o, dev_count_o, err_o}, 0);

    for (int i = 0; i < NV; i++) run_case(VEC[i], -1, $sformatf("vec%0d", i));

    // R10: results hold with start low
    repeat (6) @(negedge clk);
    chk(done_o && dev_count_o == 4'd5 && err_o == 2'd1, "R10 hold after done",
        {done_o, dev_count_o, err_o}, {1'b1, 4'd5, 2'd1});

    // R10: start during command phase and during read phase is ignored
    d2 = '{4'd2, 2'd1, 1'b1, 2'd0, 4'd0, 4'd2, 2'd0, 5'd3, 2'd0};
    run_case(d2, 1, "start in command phase");
    run_case(d2, 4, "start in read phase");

    // R7: address fault on the last possible device
    d2 = '{4'd8, 2'd0, 1'b0, 2'd2, 4'd7, 4'd7, 2'd1, 5'd8, 2'd0};
    run_case(d2, -1, "addr fault at 7");

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule